// File: doc/BRIEF.md
# Remote Key Output Pulse Generator

This block sits behind an infrared remote-control frame receiver. Each time the receiver has verified a frame, it raises a one-cycle strobe together with the index of the key that frame carried. The generator turns that stream of strobes into a bank of per-key output lines in three styles. A one-shot line gives a fixed-length pulse. A hold line stays high for as long as repeated frames for its key keep coming, and it drops a fixed release time after the last one. A toggle line flips its state once per fresh key press.

The block runs on the slow receiver clock, nominally 38 kHz, and all timing is counted in clock cycles. At that rate the defaults of 4066 and 6080 cycles correspond to roughly 107 ms and 160 ms. Key indices are assigned in ranges. The first `N_SP` indices drive the one-shot lines, the next `N_HP` drive the hold lines and the next `N_CP` drive the toggle lines. A control input enables an interlock in which a hold line for either of the two lowest hold keys, on going high, forces the first toggle line low.

Top module: `keyout_pulse_gen`

## Requirements
- R1: A synchronous active-high reset drives every one-shot, hold and toggle output low, and clears all internal timers.
- R2: A strobe for one-shot key k (index k, 0 <= k < N_SP) while `single_o[k]` is low raises `single_o[k]` on the next clock edge. The line then stays high for exactly SP_TICKS cycles.
- R3: A strobe for a one-shot key whose line is already high is ignored. The pulse is neither extended nor restarted.
- R4: A strobe for hold key j (index N_SP+j) sets `hold_o[j]` high on the next edge and restarts its release count. The line falls exactly HP_TICKS cycles after the last strobe for that key.
- R5: Each hold line has its own timer, so any number of hold lines may be high at the same time when their keys' strobes are interleaved.
- R6: A strobe for toggle key c (index N_SP+N_HP+c) inverts `cyclic_o[c]` only when no strobe for that key arrived in the preceding HP_TICKS cycles. Strobes inside that window leave the line unchanged and extend the window.
- R7: With `interlock_en` high, a strobe that raises `hold_o[0]` or `hold_o[1]` from low forces `cyclic_o[0]` low on the same edge. With `interlock_en` low, hold activity never affects the toggle lines.
- R8: Strobes whose index is N_SP+N_HP+N_CP or larger have no effect on any output.
- R9: While `strobe` is low, `key_idx` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock (nominally 38 kHz) |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One-cycle pulse marking a verified frame |
| key_idx | input | KEY_W | Key index carried by the frame, valid with strobe |
| interlock_en | input | 1 | Enables the hold-clears-first-toggle interlock |
| single_o | output | N_SP | One-shot outputs |
| hold_o | output | N_HP | Hold outputs |
| cyclic_o | output | N_CP | Toggle outputs |

## Verification
The bench builds the block with three one-shot keys, three hold keys and two toggle keys. It uses a 4-bit index, SP_TICKS of 5 and HP_TICKS of 8. With these short counts, pulse ends, release expiry, retriggers that land on the final count cycle, and toggle presses that fall just inside or just outside the release window all occur many times within a few thousand cycles. The 4-bit index leaves eight unused key values, so strobes for indices that map to no output are also exercised.

// File: rtl/kpg_pkg.sv
package kpg_pkg;

    parameter int unsigned TMR_W = 16;

    typedef logic [TMR_W-1:0] ticks_t;

    typedef struct packed {
        logic   busy;
        ticks_t left;
    } tmr_s;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_SINGLE,
        KIND_HOLD,
        KIND_CYCLIC
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] slot;
    } key_sel_s;

    // Map a flat key index onto an output style and a slot within it.
    function automatic key_sel_s classify(input int unsigned idx,
                                          input int unsigned n_sp,
                                          input int unsigned n_hp,
                                          input int unsigned n_cp);
        key_sel_s r;
        r.kind = KIND_NONE;
        r.slot = '0;
        if (idx < n_sp) begin
            r.kind = KIND_SINGLE;
            r.slot = 8'(idx);
        end else if (idx < n_sp + n_hp) begin
            r.kind = KIND_HOLD;
            r.slot = 8'(idx - n_sp);
        end else if (idx < n_sp + n_hp + n_cp) begin
            r.kind = KIND_CYCLIC;
            r.slot = 8'(idx - n_sp - n_hp);
        end
        return r;
    endfunction

endpackage

// File: rtl/kpg_decode.sv
module kpg_decode
    import kpg_pkg::*;
#(
    parameter int unsigned N_SP  = 5,
    parameter int unsigned N_HP  = 5,
    parameter int unsigned N_CP  = 2,
    parameter int unsigned KEY_W = 5
) (
    input  logic             strobe,
    input  logic [KEY_W-1:0] key_idx,
    output logic [N_SP-1:0]  sp_hit,
    output logic [N_HP-1:0]  hp_hit,
    output logic [N_CP-1:0]  cp_hit
);

    key_sel_s sel;

    always_comb begin
        sel = classify(int'(key_idx), N_SP, N_HP, N_CP);
        for (int i = 0; i < int'(N_SP); i++)
            sp_hit[i] = strobe && (sel.kind == KIND_SINGLE) && (sel.slot == 8'(i));
        for (int i = 0; i < int'(N_HP); i++)
            hp_hit[i] = strobe && (sel.kind == KIND_HOLD) && (sel.slot == 8'(i));
        for (int i = 0; i < int'(N_CP); i++)
            cp_hit[i] = strobe && (sel.kind == KIND_CYCLIC) && (sel.slot == 8'(i));
    end

endmodule

// File: rtl/kpg_timer.sv
module kpg_timer
    import kpg_pkg::*;
#(
    parameter int unsigned TICKS  = 4066,
    parameter bit          RETRIG = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic busy,
    output logic fresh
);

    tmr_s st;
    logic start;

    assign fresh = trig && !st.busy;

    generate
        if (RETRIG) begin : g_retrig
            assign start = trig;
        end else begin : g_oneshot
            assign start = fresh;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start) begin
            st.busy <= 1'b1;
            st.left <= ticks_t'(TICKS - 1);
        end else if (st.busy) begin
            if (st.left == '0) st.busy <= 1'b0;
            else               st.left <= st.left - 1'b1;
        end
    end

    assign busy = st.busy;

endmodule

// File: rtl/kpg_toggle.sv
module kpg_toggle #(
    parameter int unsigned GAP = 6080
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic clear,
    output logic q
);

    logic held;
    logic press;

    kpg_timer #(.TICKS(GAP), .RETRIG(1'b1)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .busy (held),
        .fresh(press)
    );

    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (clear) q <= 1'b0;
        else if (press) q <= ~q;
    end

endmodule

// File: rtl/keyout_pulse_gen.sv
module keyout_pulse_gen #(
    parameter int unsigned N_SP     = 5,
    parameter int unsigned N_HP     = 5,
    parameter int unsigned N_CP     = 2,
    parameter int unsigned KEY_W    = 5,
    parameter int unsigned SP_TICKS = 4066,
    parameter int unsigned HP_TICKS = 6080
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [KEY_W-1:0] key_idx,
    input  logic             interlock_en,
    output logic [N_SP-1:0]  single_o,
    output logic [N_HP-1:0]  hold_o,
    output logic [N_CP-1:0]  cyclic_o
);

    localparam int unsigned N_LOCK = (N_HP < 2) ? N_HP : 2;

    logic [N_SP-1:0] sp_hit;
    logic [N_HP-1:0] hp_hit;
    logic [N_CP-1:0] cp_hit;
    logic [N_HP-1:0] hp_rise;
    logic [N_SP-1:0] sp_fresh;
    logic            lock_clr;

    kpg_decode #(.N_SP(N_SP), .N_HP(N_HP), .N_CP(N_CP), .KEY_W(KEY_W)) u_dec (
        .strobe (strobe),
        .key_idx(key_idx),
        .sp_hit (sp_hit),
        .hp_hit (hp_hit),
        .cp_hit (cp_hit)
    );

    genvar gi;
    generate
        for (gi = 0; gi < int'(N_SP); gi++) begin : g_sp
            kpg_timer #(.TICKS(SP_TICKS), .RETRIG(1'b0)) u_sp (
                .clk  (clk),
                .rst  (rst),
                .trig (sp_hit[gi]),
                .busy (single_o[gi]),
                .fresh(sp_fresh[gi])
            );
        end

        for (gi = 0; gi < int'(N_HP); gi++) begin : g_hp
            kpg_timer #(.TICKS(HP_TICKS), .RETRIG(1'b1)) u_hp (
                .clk  (clk),
                .rst  (rst),
                .trig (hp_hit[gi]),
                .busy (hold_o[gi]),
                .fresh(hp_rise[gi])
            );
        end
    endgenerate

    assign lock_clr = interlock_en && (|hp_rise[N_LOCK-1:0]);

    generate
        for (gi = 0; gi < int'(N_CP); gi++) begin : g_cp
            if (gi == 0) begin : g_lock
                kpg_toggle #(.GAP(HP_TICKS)) u_cp (
                    .clk  (clk),
                    .rst  (rst),
                    .trig (cp_hit[gi]),
                    .clear(lock_clr),
                    .q    (cyclic_o[gi])
                );
            end else begin : g_free
                kpg_toggle #(.GAP(HP_TICKS)) u_cp (
                    .clk  (clk),
                    .rst  (rst),
                    .trig (cp_hit[gi]),
                    .clear(1'b0),
                    .q    (cyclic_o[gi])
                );
            end
        end
    endgenerate

endmodule

// File: rtl/kpg_checker.sv
module kpg_checker #(
    parameter int unsigned N_SP     = 5,
    parameter int unsigned N_HP     = 5,
    parameter int unsigned N_CP     = 2,
    parameter int unsigned KEY_W    = 5,
    parameter int unsigned SP_TICKS = 4066,
    parameter int unsigned HP_TICKS = 6080
) (
    input logic             clk,
    input logic             rst,
    input logic             strobe,
    input logic [KEY_W-1:0] key_idx,
    input logic             interlock_en,
    input logic [N_SP-1:0]  single_o,
    input logic [N_HP-1:0]  hold_o,
    input logic [N_CP-1:0]  cyclic_o
);

    localparam logic [KEY_W-1:0] K_SP0 = KEY_W'(0);
    localparam logic [KEY_W-1:0] K_HP0 = KEY_W'(N_SP);
    localparam logic [KEY_W-1:0] K_CP1 = KEY_W'(N_SP + N_HP + 1);

    int unsigned sp_run;
    int unsigned hp_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_run <= 0;
            hp_gap <= 0;
        end else begin
            sp_run <= single_o[0] ? sp_run + 1 : 0;
            if (strobe && key_idx == K_HP0) hp_gap <= 0;
            else if (hp_gap <= HP_TICKS)    hp_gap <= hp_gap + 1;
        end
    end

    AST_SP_START: assert property (@(posedge clk) disable iff (rst)
        (strobe && key_idx == K_SP0 && !single_o[0]) |=> single_o[0]); // R2

    AST_SP_NO_EXTEND: assert property (@(posedge clk) disable iff (rst)
        single_o[0] |-> (sp_run < SP_TICKS)); // R3

    AST_HP_RETRIG: assert property (@(posedge clk) disable iff (rst)
        (strobe && key_idx == K_HP0) |=> hold_o[0]); // R4

    AST_HP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o[0]) |-> (hp_gap == HP_TICKS)); // R4

    AST_CP_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cyclic_o[N_CP-1]) |-> $past(strobe && key_idx == K_CP1)); // R6

    AST_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
        (interlock_en && strobe && key_idx == K_HP0 && !hold_o[0]) |=> !cyclic_o[0]); // R7

endmodule

bind keyout_pulse_gen kpg_checker #(
    .N_SP(N_SP), .N_HP(N_HP), .N_CP(N_CP), .KEY_W(KEY_W),
    .SP_TICKS(SP_TICKS), .HP_TICKS(HP_TICKS)
) u_chk (.*);

// File: tb/keyout_pulse_gen_test.sv
module keyout_pulse_gen_test;

    localparam int NS = 3, NH = 3, NC = 2, KW = 4, ST = 5, HT = 8;
    localparam int HB = NS, CB = NS + NH, NK = NS + NH + NC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe = 1'b0;
    logic [KW-1:0] key_idx = '0;
    logic          interlock_en = 1'b0;
    logic [NS-1:0] single_o;
    logic [NH-1:0] hold_o;
    logic [NC-1:0] cyclic_o;

    int n_chk = 0, n_bad = 0;

    keyout_pulse_gen #(.N_SP(NS), .N_HP(NH), .N_CP(NC), .KEY_W(KW),
                       .SP_TICKS(ST), .HP_TICKS(HT)) uut (.*);

    always #10 clk = ~clk;

    // Reference model built from the requirements.
    logic [NS-1:0] es;  int sl[NS];
    logic [NH-1:0] eh;  int hl[NH];
    logic [NC-1:0] ec;  logic cb[NC]; int cl[NC];

    function automatic bit hit(int k);
        return strobe && int'(key_idx) == k;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            es = '0; eh = '0; ec = '0;
            for (int i = 0; i < NC; i++) cb[i] = 1'b0;
        end else begin
            if (interlock_en && ((hit(HB) && !eh[0]) || (hit(HB + 1) && !eh[1]))) ec[0] = 1'b0;
            for (int i = 0; i < NS; i++) begin
                if (hit(i) && !es[i]) begin es[i] = 1'b1; sl[i] = ST - 1; end
                else if (es[i]) begin if (sl[i] == 0) es[i] = 1'b0; else sl[i]--; end
            end
            for (int i = 0; i < NH; i++) begin
                if (hit(HB + i)) begin eh[i] = 1'b1; hl[i] = HT - 1; end
                else if (eh[i]) begin if (hl[i] == 0) eh[i] = 1'b0; else hl[i]--; end
            end
            for (int i = 0; i < NC; i++) begin
                if (hit(CB + i)) begin
                    if (!cb[i]) ec[i] = ~ec[i];
                    cb[i] = 1'b1; cl[i] = HT - 1;
                end else if (cb[i]) begin if (cl[i] == 0) cb[i] = 1'b0; else cl[i]--; end
            end
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " single"}, int'(single_o), int'(es));
        cmp({tag, " hold"},   int'(hold_o),   int'(eh));
        cmp({tag, " cyclic"}, int'(cyclic_o), int'(ec));
    endtask

    task automatic step(input logic s, input int k, input string tag);
        strobe = s; key_idx = KW'(k);
        @(posedge clk); @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int highs;
        void'($urandom(32'd20240607));
        @(negedge clk);
        idle(3, "R1");
        cmp("R1 reset single", int'(single_o), 0);
        rst = 1'b0;

        // R2/R3: one-shot width, retrigger ignored
        step(1'b1, 0, "R2");
        highs = single_o[0] ? 1 : 0;
        for (int i = 0; i < 12; i++) begin
            step(i == 1 || i == 3, 0, "R3");
            highs += single_o[0] ? 1 : 0;
        end
        cmp("R3 one-shot high cycles", highs, ST);

        // R4: hold retrigger and release
        step(1'b1, HB, "R4"); idle(4, "R4"); step(1'b1, HB, "R4");
        highs = 1;
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 0, "R4");
            highs += hold_o[0] ? 1 : 0;
        end
        cmp("R4 hold cycles after last strobe", highs, HT);

        // R5: three hold lines in parallel
        for (int i = 0; i < 6; i++) step(1'b1, HB + (i % NH), "R5");
        cmp("R5 all holds high", int'(hold_o), (1 << NH) - 1);
        idle(HT + 2, "R5");

        // R6: toggle on fresh press only
        step(1'b1, CB + 1, "R6"); idle(HT - 2, "R6");
        step(1'b1, CB + 1, "R6");
        cmp("R6 held press no retoggle", int'(cyclic_o[1]), 1);
        idle(HT + 1, "R6"); step(1'b1, CB + 1, "R6");
        cmp("R6 new press toggles", int'(cyclic_o[1]), 0);
        idle(HT + 2, "R6");

        // R7: interlock on and off
        step(1'b1, CB, "R7"); idle(HT + 2, "R7");
        interlock_en = 1'b0; step(1'b1, HB + 1, "R7");
        cmp("R7 no interlock keeps toggle", int'(cyclic_o[0]), 1);
        idle(HT + 2, "R7");
        interlock_en = 1'b1; step(1'b1, HB + 1, "R7");
        cmp("R7 interlock clears toggle", int'(cyclic_o[0]), 0);
        idle(HT + 2, "R7");

        // R8/R9: unused indices and idle strobe
        for (int k = NK; k < (1 << KW); k++) step(1'b1, k, "R8");
        cmp("R8 nothing active", int'({single_o, hold_o, cyclic_o}), 0);
        for (int k = 0; k < NK; k++) step(1'b0, k, "R9");
        cmp("R9 nothing active", int'({single_o, hold_o}), 0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) interlock_en = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0) step(1'b1, $urandom_range(0, NK), "R5 random");
            else step(1'b0, $urandom_range(0, 15), "R9 random");
        end

        rst = 1'b1; idle(2, "R1");
        cmp("R1 reset after activity", int'({single_o, hold_o, cyclic_o}), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule